// File: doc/BRIEF.md
# Program-Driven Page-Mode DRAM Strobe Sequencer

This block sits between a signal processor's external memory bus and a bank of page-mode DRAM. The processor has no DRAM controller of its own, so every DRAM cycle comes from the running program. Two address windows are carved out of the external address space. Writes into the control window open or close a DRAM row, or do both as a refresh. Accesses into the data window become column strobes inside the open row. The low address bits go straight to the DRAM address pins. The row address comes from the access that opens the row, and the column address comes from the access in the data window.

Everything runs on one fast reference clock that samples the processor bus. An access starts on the first clock edge that sees the bus strobe low after it was high. The DRAM write enable is the processor write strobe delayed by a fixed number of reference-clock cycles. A guard counter stops the row strobe from falling again before the minimum precharge time has passed. Requests that break that rule, or that break the open/close protocol, are dropped and reported on one-cycle error pulses.

Switching rows costs extra bus cycles beyond the column access: one write to open the row and one write to close it. Software therefore groups its accesses by page. A single long-word write that selects both memory spaces gives a row-only refresh.

Top module: `dram_seq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ras_n`, `cas_n` and `dram_we_n` are high and both error outputs are low.
- R2: `dram_addr` always equals the low `COL_W` bits of `bus_addr` (default 10), combinationally, whatever the strobe state.
- R3: An access start that is a write (`bus_wr_n` low) with `sel_x` high and `sel_y` low, at an address whose bits above `COL_W` match `CTRL_BASE` (default control window 0xF000–0xF3FF), drives `ras_n` low from the next clock edge on, provided no row is open and the precharge time has passed.
- R4: An access start that is a control-window write with `sel_y` high and `sel_x` low drives `ras_n` high from the next clock edge on.
- R5: While a row is open, every clock edge that samples `bus_strobe_n` low at an address whose upper bits match `DATA_BASE` (default data window 0xF400–0xF7FF) drives `cas_n` low for the following cycle. Reads and writes are treated the same. The first edge that samples the strobe high returns `cas_n` high.
- R6: Once `ras_n` rises, it stays high for at least `T_RP` cycles (default 3). An open or refresh request that arrives fewer than `T_RP` edges after the rise is dropped, `ras_n` stays high, and `early_open_err` is high for exactly one cycle.
- R7: A control-window write with both `sel_x` and `sel_y` high, made while no row is open and precharge is complete, holds `ras_n` low for exactly one cycle. It then raises `ras_n` and starts the precharge guard.
- R8: Two protocol violations make `protocol_err` high for exactly one cycle. The first is a data-window access start while no row is open; `cas_n` stays high for that access. The second is an open request while a row is already open; the row stays open.
- R9: The following leave `ras_n`, `cas_n` and both error outputs unchanged: control-window reads, accesses outside both windows, and the further cycles of an access whose strobe stays low.
- R10: `dram_we_n` equals `bus_wr_n` delayed by `WE_DLY` clock cycles (default 2, which is 40 ns with a 50 MHz reference clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock that samples the processor bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Processor external address |
| bus_strobe_n | input | 1 | Processor bus strobe, low during an access |
| bus_wr_n | input | 1 | Processor write strobe, low during a write |
| sel_x | input | 1 | Access targets the X data space |
| sel_y | input | 1 | Access targets the Y data space |
| dram_addr | output | COL_W (10) | Row or column address to the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Delayed DRAM write enable, active low |
| early_open_err | output | 1 | One-cycle pulse: open or refresh request dropped during precharge |
| protocol_err | output | 1 | One-cycle pulse: column access with no open row, or open request with a row already open |

## Verification
The hardest case to reach is an open request one edge after `ras_n` rises. An access start needs the strobe to be high on the edge before it, so two ordinary writes cannot be that close together. Because a refresh closes the row on the edge after its start, the bench issues a refresh and then an open-window write on the very next access start, which lands one edge after the rise. The bench also sweeps the gap between a close and the next open from two edges up to two past `T_RP`, so the last rejected case and the first accepted case sit next to each other.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   // Row strobe sequencer states
   typedef enum logic [1:0] {
      ROW_IDLE = 2'd0,
      ROW_OPEN = 2'd1,
      ROW_RFSH = 2'd2
   } row_state_e;

   // Helper: does an address fall into a window whose base is aligned to 2**low_w
   function automatic logic win_match(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input int unsigned low_w);
      return (addr >> low_w) == (base >> low_w);
   endfunction

endpackage

// File: rtl/dram_win_decode.sv
module dram_win_decode
   import dram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned COL_W     = 10,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hF000,
   parameter logic [ADDR_W-1:0] DATA_BASE = 16'hF400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_strobe_n,
   input  logic              bus_wr_n,
   input  logic              sel_x,
   input  logic              sel_y,
   output logic              open_req,
   output logic              close_req,
   output logic              rfsh_req,
   output logic              col_start,
   output logic              col_active
);
   localparam int unsigned HI_W = ADDR_W - COL_W;

   logic            strobe_q;
   logic            acc_start;
   logic            ctrl_hit;
   logic            data_hit;
   logic            ctrl_wr_start;
   logic [HI_W-1:0] addr_hi;

   assign addr_hi = bus_addr[ADDR_W-1:COL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= bus_strobe_n;
   end

   assign acc_start     = !bus_strobe_n && strobe_q;
   assign ctrl_hit      = (addr_hi == CTRL_BASE[ADDR_W-1:COL_W]);
   assign data_hit      = (addr_hi == DATA_BASE[ADDR_W-1:COL_W]);
   assign ctrl_wr_start = acc_start && ctrl_hit && !bus_wr_n;

   assign open_req   = ctrl_wr_start &&  sel_x && !sel_y;
   assign close_req  = ctrl_wr_start && !sel_x &&  sel_y;
   assign rfsh_req   = ctrl_wr_start &&  sel_x &&  sel_y;
   assign col_start  = acc_start && data_hit;
   assign col_active = !bus_strobe_n && data_hit;

   // R9: a held strobe never yields two consecutive access starts
   // R9
   start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open_req || rfsh_req || col_start) |=> !(open_req || rfsh_req || col_start));

endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
   import dram_seq_pkg::*;
#(
   parameter int unsigned T_RP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic close_req,
   input  logic rfsh_req,
   output logic ras_n,
   output logic row_open,
   output logic early_err,
   output logic dup_open_err
);
   localparam int unsigned PC_W    = (T_RP < 2) ? 1 : $clog2(T_RP + 1);
   localparam logic [PC_W-1:0] PC_LOAD = PC_W'(T_RP - 1);

   row_state_e      st;
   logic [PC_W-1:0] pc_cnt;
   logic            pc_busy;

   assign pc_busy  = (pc_cnt != '0);
   assign ras_n    = (st == ROW_IDLE);
   assign row_open = (st == ROW_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ROW_IDLE;
         pc_cnt       <= '0;
         early_err    <= 1'b0;
         dup_open_err <= 1'b0;
      end else begin
         early_err    <= 1'b0;
         dup_open_err <= 1'b0;
         if (pc_busy) pc_cnt <= pc_cnt - 1'b1;
         unique case (st)
            ROW_IDLE: begin
               if (open_req || rfsh_req) begin
                  if (pc_busy)       early_err <= 1'b1;
                  else if (rfsh_req) st <= ROW_RFSH;
                  else               st <= ROW_OPEN;
               end
            end
            ROW_OPEN: begin
               if (close_req || rfsh_req) begin
                  st     <= ROW_IDLE;
                  pc_cnt <= PC_LOAD;
               end else if (open_req) begin
                  dup_open_err <= 1'b1;
               end
            end
            ROW_RFSH: begin
               st     <= ROW_IDLE;
               pc_cnt <= PC_LOAD;
               if (open_req || rfsh_req) early_err <= 1'b1;
            end
            default: st <= ROW_IDLE;
         endcase
      end
   end

   // Independent high-time tracker used only by the precharge check
   logic [PC_W:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hi_run <= (PC_W+1)'(T_RP);
      else if (!ras_n)          hi_run <= '0;
      else if (hi_run < T_RP)   hi_run <= hi_run + 1'b1;
   end

   // R6
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ras_n) && !ras_n) |-> (hi_run >= T_RP));

   // R6
   early_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early_err |-> (ras_n && $stable(ras_n)));

   // R7
   rfsh_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ROW_RFSH) |=> (ras_n && pc_busy));

   // R8
   dup_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dup_open_err |-> !ras_n);

endmodule

// File: rtl/dram_col_gate.sv
module dram_col_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic col_start,
   input  logic col_active,
   input  logic row_open,
   output logic cas_n,
   output logic col_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cas_n   <= 1'b1;
         col_err <= 1'b0;
      end else begin
         cas_n   <= !(col_active && row_open);
         col_err <= col_start && !row_open;
      end
   end

   // R8
   col_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_start && !row_open) |=> (cas_n && col_err));

endmodule

// File: rtl/dram_we_delay.sv
module dram_we_delay #(
   parameter int unsigned DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_in_n,
   output logic wr_out_n
);
   generate
      if (DLY == 0) begin : g_pass
         assign wr_out_n = wr_in_n;
      end else begin : g_shift
         logic [DLY-1:0] taps;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps <= '1;
            else        taps <= {taps[DLY-1:0], wr_in_n} >> 0;
         end
         assign wr_out_n = taps[DLY-1];

         // R10
         we_first_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_in_n) == taps[0]);
      end
   endgenerate

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
   import dram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned COL_W  = 10,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hF000,
   parameter logic [ADDR_W-1:0] DATA_BASE = 16'hF400,
   parameter int unsigned T_RP   = 3,
   parameter int unsigned WE_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_strobe_n,
   input  logic              bus_wr_n,
   input  logic              sel_x,
   input  logic              sel_y,
   output logic [COL_W-1:0]  dram_addr,
   output logic              ras_n,
   output logic              cas_n,
   output logic              dram_we_n,
   output logic              early_open_err,
   output logic              protocol_err
);
   localparam logic [COL_W-1:0] LOW_ZERO = '0;

   // Elaboration-time parameter checks
   generate
      if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_col
         $error("COL_W must lie between 1 and ADDR_W-1");
      end
      if (T_RP < 1) begin : g_bad_trp
         $error("T_RP must be at least 1");
      end
      if (CTRL_BASE[COL_W-1:0] != LOW_ZERO || DATA_BASE[COL_W-1:0] != LOW_ZERO) begin : g_bad_align
         $error("window bases must be aligned to the window size");
      end
      if (CTRL_BASE[ADDR_W-1:COL_W] == DATA_BASE[ADDR_W-1:COL_W]) begin : g_bad_overlap
         $error("control and data windows must differ");
      end
   endgenerate

   logic open_req, close_req, rfsh_req, col_start, col_active;
   logic row_open, dup_open_err, col_err;

   assign dram_addr = bus_addr[COL_W-1:0];

   dram_win_decode #(
      .ADDR_W(ADDR_W), .COL_W(COL_W),
      .CTRL_BASE(CTRL_BASE), .DATA_BASE(DATA_BASE)
   ) u_dec (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_strobe_n(bus_strobe_n), .bus_wr_n(bus_wr_n),
      .sel_x(sel_x), .sel_y(sel_y),
      .open_req(open_req), .close_req(close_req), .rfsh_req(rfsh_req),
      .col_start(col_start), .col_active(col_active)
   );

   dram_row_seq #(.T_RP(T_RP)) u_row (
      .clk(clk), .rst_n(rst_n),
      .open_req(open_req), .close_req(close_req), .rfsh_req(rfsh_req),
      .ras_n(ras_n), .row_open(row_open),
      .early_err(early_open_err), .dup_open_err(dup_open_err)
   );

   dram_col_gate u_col (
      .clk(clk), .rst_n(rst_n),
      .col_start(col_start), .col_active(col_active), .row_open(row_open),
      .cas_n(cas_n), .col_err(col_err)
   );

   dram_we_delay #(.DLY(WE_DLY)) u_we (
      .clk(clk), .rst_n(rst_n),
      .wr_in_n(bus_wr_n), .wr_out_n(dram_we_n)
   );

   assign protocol_err = dup_open_err || col_err;

   // R5
   cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R8
   proto_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      protocol_err |=> !protocol_err);

endmodule

// File: tb/dram_seq_top_tb.sv
module dram_seq_top_tb;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned COL_W  = 10;
   localparam logic [15:0] CTRL   = 16'hF000;
   localparam logic [15:0] DATA   = 16'hF400;
   localparam int unsigned T_RP   = 3;
   localparam int unsigned WE_DLY = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_strobe_n = 1'b1;
   logic              bus_wr_n = 1'b1;
   logic              sel_x = 1'b0;
   logic              sel_y = 1'b0;
   logic [COL_W-1:0]  dram_addr;
   logic              ras_n, cas_n, dram_we_n, early_open_err, protocol_err;

   int n_vec = 0;
   int n_bad = 0;
   bit mon_en = 1'b0;
   logic [7:0] wr_hist = '1;

   always #10 clk = !clk;

   dram_seq_top #(
      .ADDR_W(ADDR_W), .COL_W(COL_W), .CTRL_BASE(CTRL), .DATA_BASE(DATA),
      .T_RP(T_RP), .WE_DLY(WE_DLY)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe_n(bus_strobe_n),
      .bus_wr_n(bus_wr_n), .sel_x(sel_x), .sel_y(sel_y), .dram_addr(dram_addr),
      .ras_n(ras_n), .cas_n(cas_n), .dram_we_n(dram_we_n),
      .early_open_err(early_open_err), .protocol_err(protocol_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [15:0] a, input logic wr, input logic x, input logic y);
      bus_addr = a; bus_strobe_n = 1'b0; bus_wr_n = !wr; sel_x = x; sel_y = y;
   endtask

   task automatic release_bus();
      bus_strobe_n = 1'b1; bus_wr_n = 1'b1; sel_x = 1'b0; sel_y = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   // R10: write-enable history model, sampled at each edge
   always @(posedge clk) begin
      if (!rst_n) wr_hist <= '1;
      else        wr_hist <= {wr_hist[6:0], bus_wr_n};
   end

   always @(negedge clk) begin
      #2;
      if (mon_en) chk("R10 we delay", {31'd0, dram_we_n}, {31'd0, wr_hist[WE_DLY-1]});
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      @(negedge clk);
      cyc();
      chk("R1 ras_n in reset", {31'd0, ras_n}, 1);
      chk("R1 cas_n in reset", {31'd0, cas_n}, 1);
      chk("R1 we_n in reset", {31'd0, dram_we_n}, 1);
      rst_n = 1'b1;
      cyc();
      chk("R1 ras_n after reset", {31'd0, ras_n}, 1);
      chk("R1 errors after reset", {30'd0, early_open_err, protocol_err}, 0);
      mon_en = 1'b1;

      // R2 address pass-through sweep, strobe idle and active
      for (int i = 0; i < 64; i++) begin
         bus_addr = 16'((i * 1031) ^ (i << 9));
         bus_strobe_n = i[0];
         #1;
         chk("R2 dram_addr", {22'd0, dram_addr}, {22'd0, bus_addr[9:0]});
      end
      release_bus();
      bus_addr = 16'h0000;
      idle(T_RP + 2);

      // R3 open row, strobe held low 3 cycles (R9 held strobe no retrigger)
      drive(CTRL + 16'h0155, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) begin
         cyc();
         chk("R3 ras_n low after open", {31'd0, ras_n}, 0);
         chk("R9 held open strobe no error", {31'd0, protocol_err}, 0);
      end
      release_bus();
      cyc();

      // R5 column sweep: lengths 1..3, read and write, both spaces
      for (int len = 1; len <= 3; len++) begin
         for (int wr = 0; wr < 2; wr++) begin
            drive(DATA + 16'(len * 37 + wr), wr[0], wr[0], !wr[0]);
            for (int k = 0; k < len; k++) begin
               cyc();
               chk("R5 cas_n low during access", {31'd0, cas_n}, 0);
            end
            release_bus();
            cyc();
            chk("R5 cas_n high after access", {31'd0, cas_n}, 1);
            chk("R5 ras_n held", {31'd0, ras_n}, 0);
         end
      end

      // R8 open while already open
      drive(CTRL + 16'h0011, 1'b1, 1'b1, 1'b0);
      cyc();
      chk("R8 dup open flags error", {31'd0, protocol_err}, 1);
      chk("R8 dup open keeps row", {31'd0, ras_n}, 0);
      release_bus();
      cyc();
      chk("R8 protocol_err one cycle", {31'd0, protocol_err}, 0);

      // R9 ignored accesses: control read with sel_y, outside-window writes
      drive(CTRL + 16'h0002, 1'b0, 1'b0, 1'b1);
      cyc();
      chk("R9 ctrl read no close", {31'd0, ras_n}, 0);
      release_bus();
      cyc();
      for (int i = 0; i < 4; i++) begin
         drive(16'(16'h0123 + i * 16'h3000), 1'b1, i[0], !i[0]);
         cyc();
         chk("R9 outside window ras", {31'd0, ras_n}, 0);
         chk("R9 outside window cas", {31'd0, cas_n}, 1);
         chk("R9 outside window errors", {30'd0, early_open_err, protocol_err}, 0);
         release_bus();
         cyc();
      end

      // R4 close
      drive(CTRL + 16'h0003, 1'b1, 1'b0, 1'b1);
      cyc();
      chk("R4 ras_n high after close", {31'd0, ras_n}, 1);
      release_bus();
      cyc();

      // R8 column access with no row
      idle(T_RP + 2);
      drive(DATA + 16'h0044, 1'b0, 1'b1, 1'b0);
      cyc();
      chk("R8 col without row error", {31'd0, protocol_err}, 1);
      chk("R8 col without row cas", {31'd0, cas_n}, 1);
      cyc();
      chk("R8 col error one cycle", {31'd0, protocol_err}, 0);
      chk("R8 cas stays high", {31'd0, cas_n}, 1);
      release_bus();
      cyc();

      // R6 precharge sweep: gap j edges between close and reopen
      for (int j = 2; j <= T_RP + 2; j++) begin
         idle(T_RP + 2);
         if (ras_n == 1'b0) begin
            drive(CTRL, 1'b1, 1'b0, 1'b1);
            cyc();
            release_bus();
            idle(T_RP + 2);
         end
         drive(CTRL + 16'(j), 1'b1, 1'b1, 1'b0);
         cyc();
         chk("R6 setup open", {31'd0, ras_n}, 0);
         release_bus();
         cyc();
         drive(CTRL, 1'b1, 1'b0, 1'b1);
         cyc();
         chk("R6 close", {31'd0, ras_n}, 1);
         release_bus();
         idle(j - 1);
         drive(CTRL + 16'h0200, 1'b1, 1'b1, 1'b0);
         cyc();
         chk("R6 reopen ras_n", {31'd0, ras_n}, (j >= T_RP) ? 0 : 1);
         chk("R6 early error", {31'd0, early_open_err}, (j >= T_RP) ? 0 : 1);
         release_bus();
         cyc();
         chk("R6 early error one cycle", {31'd0, early_open_err}, 0);
      end
      if (ras_n == 1'b0) begin
         drive(CTRL, 1'b1, 1'b0, 1'b1);
         cyc();
         release_bus();
      end

      // R7 refresh sweep, each followed by an open one edge after the rise
      for (int r = 0; r < 4; r++) begin
         idle(T_RP + 2);
         drive(CTRL + 16'(r * 200), 1'b1, 1'b1, 1'b1);
         cyc();
         chk("R7 refresh ras_n low", {31'd0, ras_n}, 0);
         release_bus();
         cyc();
         chk("R7 refresh ras_n back high", {31'd0, ras_n}, 1);
         drive(CTRL + 16'h0001, 1'b1, 1'b1, r[0]);
         cyc();
         chk("R6 open one edge after rise", {31'd0, ras_n}, 1);
         chk("R6 early error after refresh", {31'd0, early_open_err}, 1);
         release_bus();
         cyc();
      end

      // R7 refresh accepted after precharge then normal open
      idle(T_RP + 2);
      drive(CTRL + 16'h0077, 1'b1, 1'b1, 1'b0);
      cyc();
      chk("R3 open after refresh precharge", {31'd0, ras_n}, 0);
      release_bus();
      cyc();
      drive(CTRL, 1'b1, 1'b0, 1'b1);
      cyc();
      release_bus();
      idle(WE_DLY + 3);

      mon_en = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule